// File: doc/BRIEF.md
# Universal Bidirectional Registered Bus Transceiver

This block moves an 18-bit word between an A side and a B side, with one independent path in each direction. Each path has a storage element that acts in one of two ways. While its latch enable is high the path is transparent. While the latch enable is low, the element is a register that loads on a falling edge of that direction's strobe. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. The bidirectional pins are split into a data-in vector, a data-out vector and a per-bit drive-enable vector on each side. A pad ring outside the block combines them into tri-state pins. Data is never inverted.

The strobes and latch enables are ordinary inputs, sampled on the system clock `sys_clk`. A strobe falling edge is seen as a high sample followed by a low sample on consecutive rising edges of `sys_clk`. The load completes at the second of those edges. In transparent mode the output follows the input without any register. Storage keeps running while a direction's drive is off, so a word can be loaded or held with the pins released. An active-low asynchronous reset models power-up. It clears both stored words and the strobe history, and it releases both sides' drivers.

Top module: `bus_xcvr_univ`

## Requirements
- R1: Each direction carries DATA_W = 18 bits with no inversion: a data-out bit equals the corresponding stored or passed-through input bit.
- R2: While a direction's latch enable is 1, its data-out equals its data-in in the same cycle, whatever its strobe does, and storage loads data-in on every `sys_clk` rising edge.
- R3: While the latch enable is 0 and the strobe is held at 1, held at 0 or rises, the stored word is unchanged and is shown on data-out.
- R4: While the latch enable is 0, a strobe sampled 1 and then 0 on consecutive `sys_clk` rising edges loads data-in at the second edge, and the word appears on data-out after that edge.
- R5: When the latch enable goes from 1 to 0, storage keeps the last word that passed through and shows it until the next load or transparent period.
- R6: The B side's drive-enable vector is all ones when `ab_drive_en` is 1 and all zeros when it is 0.
- R7: The A side's drive-enable vector is all ones when `ba_drive_en_n` is 0 and all zeros when it is 1.
- R8: Passing, loading and holding work as in R2 to R5 while a direction's drive is disabled, and a word loaded while disabled appears once the drive is enabled.
- R9: Each direction responds only to its own latch enable, strobe and data-in, so activity on one path leaves the other path's outputs unchanged.
- R10: While `rst_n` is 0, both drive-enable vectors are all zeros and both stored words are 0. A strobe that is low when reset is released does not cause a load, and a strobe that is high at release followed by a low does cause a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Sampling clock for strobes and storage |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| a_din | input | 18 | Word received from the A pins |
| a_dout | output | 18 | Word to drive onto the A pins (B-to-A path) |
| a_drive | output | 18 | Per-bit drive enable for the A pins |
| b_din | input | 18 | Word received from the B pins |
| b_dout | output | 18 | Word to drive onto the B pins (A-to-B path) |
| b_drive | output | 18 | Per-bit drive enable for the B pins |
| ab_latch_en | input | 1 | A-to-B transparent enable, high = transparent |
| ab_strobe | input | 1 | A-to-B load strobe, falling edge loads |
| ab_drive_en | input | 1 | A-to-B output enable, active high |
| ba_latch_en | input | 1 | B-to-A transparent enable, high = transparent |
| ba_strobe | input | 1 | B-to-A load strobe, falling edge loads |
| ba_drive_en_n | input | 1 | B-to-A output enable, active low |

## Verification
The bench builds the block with its default DATA_W of 18. It uses patterns that set the top bit (0x3FFFF, 0x2AAAA) next to patterns with only low bits set, so an inversion, a lost upper bit or a swapped lane shows up on data-out. With 18 bits, every function-table mode can be walked in both directions with distinct words per row. Each stored word can therefore be traced back to the exact row that loaded it.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
    localparam int unsigned DATA_W = 18;

    typedef enum logic [1:0] {
        PATH_HOLD    = 2'd0,
        PATH_PASS    = 2'd1,
        PATH_CAPTURE = 2'd2
    } path_mode_e;
endpackage

// File: rtl/bus_xcvr_path.sv
module bus_xcvr_path
    import bus_xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             latch_en_i,
    input  logic             strobe_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    localparam logic [WIDTH-1:0] STORE_RST = '0;

    typedef struct packed {
        logic [WIDTH-1:0] store;
        logic             strobe_prev;
    } path_state_t;

    path_state_t state_d, state_q;
    path_mode_e  mode;

    always_comb begin
        state_d = state_q;
        mode    = PATH_HOLD;
        if (latch_en_i) begin
            mode = PATH_PASS;
        end else if (state_q.strobe_prev && !strobe_i) begin
            mode = PATH_CAPTURE;
        end
        case (mode)
            PATH_PASS, PATH_CAPTURE: state_d.store = din_i;
            default:                 state_d.store = state_q.store;
        endcase
        state_d.strobe_prev = strobe_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.store       <= STORE_RST;
            state_q.strobe_prev <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dout_o = latch_en_i ? din_i : state_q.store;

    // R2: transparent period loads the word into storage
    assert_pass_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_en_i |=> (state_q.store == $past(din_i)));

    // R3: no strobe fall with latch closed leaves storage alone
    assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!latch_en_i && !$fell(strobe_i) && $past(rst_ni)) |=> $stable(state_q.store));

    // R4: strobe fall with latch closed captures the input word
    assert_fall_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!latch_en_i && $fell(strobe_i) && $past(rst_ni)) |=> (state_q.store == $past(din_i)));
endmodule

// File: rtl/bus_xcvr_drive.sv
module bus_xcvr_drive #(
    parameter int unsigned WIDTH      = 18,
    parameter bit          ACTIVE_LOW = 1'b0
) (
    input  logic             rst_ni,
    input  logic             en_pin_i,
    output logic [WIDTH-1:0] drive_o
);
    logic enabled;

    generate
        if (ACTIVE_LOW) begin : g_low
            assign enabled = ~en_pin_i;
        end else begin : g_high
            assign enabled = en_pin_i;
        end
    endgenerate

    assign drive_o = {WIDTH{enabled & rst_ni}};
endmodule

// File: rtl/bus_xcvr_univ.sv
module bus_xcvr_univ
    import bus_xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_din,
    output logic [WIDTH-1:0] a_dout,
    output logic [WIDTH-1:0] a_drive,
    input  logic [WIDTH-1:0] b_din,
    output logic [WIDTH-1:0] b_dout,
    output logic [WIDTH-1:0] b_drive,
    input  logic             ab_latch_en,
    input  logic             ab_strobe,
    input  logic             ab_drive_en,
    input  logic             ba_latch_en,
    input  logic             ba_strobe,
    input  logic             ba_drive_en_n
);
    localparam logic [WIDTH-1:0] ALL_ON = {WIDTH{1'b1}};

    bus_xcvr_path #(.WIDTH(WIDTH)) u_path_ab (
        .clk_i      (sys_clk),
        .rst_ni     (rst_n),
        .latch_en_i (ab_latch_en),
        .strobe_i   (ab_strobe),
        .din_i      (a_din),
        .dout_o     (b_dout)
    );

    bus_xcvr_path #(.WIDTH(WIDTH)) u_path_ba (
        .clk_i      (sys_clk),
        .rst_ni     (rst_n),
        .latch_en_i (ba_latch_en),
        .strobe_i   (ba_strobe),
        .din_i      (b_din),
        .dout_o     (a_dout)
    );

    bus_xcvr_drive #(.WIDTH(WIDTH), .ACTIVE_LOW(1'b0)) u_drive_b (
        .rst_ni   (rst_n),
        .en_pin_i (ab_drive_en),
        .drive_o  (b_drive)
    );

    bus_xcvr_drive #(.WIDTH(WIDTH), .ACTIVE_LOW(1'b1)) u_drive_a (
        .rst_ni   (rst_n),
        .en_pin_i (ba_drive_en_n),
        .drive_o  (a_drive)
    );

    // R6: B side drive polarity
    assert_b_drive_pol_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ab_drive_en ? (b_drive == ALL_ON) : (b_drive == '0));

    // R7: A side drive polarity is inverted
    assert_a_drive_pol_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ba_drive_en_n ? (a_drive == '0) : (a_drive == ALL_ON));

    // R2: transparent path presents its input on the far side
    assert_ab_transparent_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
        ab_latch_en |-> (b_dout == a_din));
endmodule

// File: tb/tb_bus_xcvr_univ.sv
`timescale 1ns/1ps
module tb_bus_xcvr_univ;
    localparam int W = 18;
    localparam int NROWS = 21;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic [W-1:0] a_dout, a_drive, b_dout, b_drive;
    logic ab_le = 1'b0, ab_st = 1'b0, ab_en = 1'b0;
    logic ba_le = 1'b0, ba_st = 1'b0, ba_en_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bus_xcvr_univ dut (
        .sys_clk(clk), .rst_n(rst_n),
        .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
        .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive),
        .ab_latch_en(ab_le), .ab_strobe(ab_st), .ab_drive_en(ab_en),
        .ba_latch_en(ba_le), .ba_strobe(ba_st), .ba_drive_en_n(ba_en_n)
    );

    // row: dir, latch_en, strobe, drive(logical), din[18], exp_dout[18], exp_drive
    localparam logic [40:0] TBL [0:NROWS-1] = '{
        {4'b0101, 18'h12345, 18'h12345, 1'b1},
        {4'b0111, 18'h00AAA, 18'h00AAA, 1'b1},
        {4'b0101, 18'h3FFFF, 18'h3FFFF, 1'b1},
        {4'b0001, 18'h11111, 18'h3FFFF, 1'b1},
        {4'b0011, 18'h22222, 18'h3FFFF, 1'b1},
        {4'b0011, 18'h33333, 18'h3FFFF, 1'b1},
        {4'b0001, 18'h0F0F0, 18'h0F0F0, 1'b1},
        {4'b0001, 18'h15555, 18'h0F0F0, 1'b1},
        {4'b0010, 18'h2AAAA, 18'h0F0F0, 1'b0},
        {4'b0000, 18'h00001, 18'h00001, 1'b0},
        {4'b0100, 18'h2468A, 18'h2468A, 1'b0},
        {4'b0000, 18'h13579, 18'h2468A, 1'b0},
        {4'b0001, 18'h00000, 18'h2468A, 1'b1},
        {4'b1011, 18'h3C3C3, 18'h00000, 1'b1},
        {4'b1001, 18'h1ABCD, 18'h1ABCD, 1'b1},
        {4'b1111, 18'h05A5A, 18'h05A5A, 1'b1},
        {4'b1101, 18'h2FEDC, 18'h2FEDC, 1'b1},
        {4'b1000, 18'h11111, 18'h2FEDC, 1'b0},
        {4'b1010, 18'h22222, 18'h2FEDC, 1'b0},
        {4'b1000, 18'h0AAAA, 18'h0AAAA, 1'b0},
        {4'b1001, 18'h3FFFF, 18'h0AAAA, 1'b1}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] other_dout;
        ab_en = 1'b1;
        ba_en_n = 1'b0;
        #1;
        // R10: reset state, drivers released even with enables active
        check("R10 b_drive in reset", b_drive, '0);
        check("R10 a_drive in reset", a_drive, '0);
        check("R10 b_dout in reset", b_dout, '0);
        check("R10 a_dout in reset", a_dout, '0);
        @(negedge clk);
        ab_en = 1'b0;
        ba_en_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        settle();

        for (int i = 0; i < NROWS; i++) begin
            logic [40:0] r;
            r = TBL[i];
            @(negedge clk);
            if (r[40] == 1'b0) begin
                ab_le = r[39]; ab_st = r[38]; ab_en = r[37]; a_din = r[36:19];
                other_dout = a_dout;
            end else begin
                ba_le = r[39]; ba_st = r[38]; ba_en_n = ~r[37]; b_din = r[36:19];
                other_dout = b_dout;
            end
            settle();
            if (r[40] == 1'b0) begin
                check($sformatf("R1 R2 R3 R4 R5 R8 row %0d b_dout", i), b_dout, r[18:1]);
                check($sformatf("R6 R8 row %0d b_drive", i), b_drive, r[0] ? ONES : '0);
                check($sformatf("R9 row %0d a_dout unchanged", i), a_dout, other_dout);
            end else begin
                check($sformatf("R1 R2 R3 R4 R8 row %0d a_dout", i), a_dout, r[18:1]);
                check($sformatf("R7 R8 row %0d a_drive", i), a_drive, r[0] ? ONES : '0);
                check($sformatf("R9 row %0d b_dout unchanged", i), b_dout, other_dout);
            end
        end

        // R2: transparent output follows input within the same cycle
        @(negedge clk);
        ab_le = 1'b1; a_din = 18'h2BEEF;
        #0.5;
        check("R2 combinational pass", b_dout, 18'h2BEEF);
        settle();

        // R10: reset mid-run with A-to-B strobe high, B-to-A strobe low
        @(negedge clk);
        ab_le = 1'b0; ab_st = 1'b1; ab_en = 1'b1;
        ba_le = 1'b0; ba_st = 1'b0; ba_en_n = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R10 async clear b_dout", b_dout, '0);
        check("R10 async clear a_dout", a_dout, '0);
        check("R10 b_drive forced off", b_drive, '0);
        check("R10 a_drive forced off", a_drive, '0);
        @(negedge clk);
        rst_n = 1'b1;
        a_din = 18'h1CAFE; b_din = 18'h2D00D;
        settle();
        check("R10 no load after release b_dout", b_dout, '0);
        check("R10 strobe low at release no load a_dout", a_dout, '0);
        check("R6 drive back after reset", b_drive, ONES);
        check("R7 drive back after reset", a_drive, ONES);
        @(negedge clk);
        ab_st = 1'b0;
        settle();
        check("R10 R4 first fall after release loads", b_dout, 18'h1CAFE);
        check("R10 B-to-A still holds zero", a_dout, '0);

        // R5: latch closes on the last passed word
        @(negedge clk);
        ba_le = 1'b1; b_din = 18'h3A5A5;
        settle();
        @(negedge clk);
        ba_le = 1'b0; b_din = 18'h01234;
        settle();
        check("R5 latch close keeps last word", a_dout, 18'h3A5A5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule